// File: doc/BRIEF.md
# Instruction Fetch Front End with Jump Predecode

This block is the front of a five-stage in-order pipeline: address issue, memory return, decode, register access and execute. Every unstalled cycle it presents one packet-aligned address to a local instruction memory that answers one cycle later with a 64-bit packet holding two 32-bit instruction slots. The returning packet is registered and presented to decode together with its address and a mask of the slots that belong to the program path.

A small predecoder inspects each returning packet. When a slot carries the unconditional-jump opcode, the next fetch address becomes the packet address plus a signed packet offset from that slot, one stage after the data arrives. This costs a single discarded fetch instead of a full flush. Every other opcode, conditional branches included, lets fetch run sequentially. Taken conditional branches come back from execute as a redirect, which discards all younger work. Each fetch in flight carries a valid bit and an epoch tag. Each redirect advances the epoch, so packets issued before it are dropped when they return.

Top module: `fetch_predecode_top`

## Requirements
- R1: While rst_ni is low, imem_addr_o equals RESET_VEC and pkt_valid_o is 0. The packet at RESET_VEC is the first one presented, two unstalled cycles after reset is released.
- R2: Without a redirect, each unstalled cycle issues the previous address plus 8. Packets reach decode in address order, one per cycle, and pkt_data_o is the memory word of pkt_addr_o.
- R3: The memory returns data one cycle after the address is presented. imem_req_o is 0 in every stalled cycle.
- R4: A slot whose bits [31:26] equal 6'h3A is an unconditional jump. Slot 0 is packet bits [31:0] and slot 1 is bits [63:32]. The next fetch goes to the packet address plus the sign-extended slot bits [25:0] times 8, and the target packet follows the jump packet after exactly one empty cycle.
- R5: If both slots are jumps, slot 0 decides the target. pkt_mask_o is 2'b01 when slot 0 is a jump and 2'b11 otherwise.
- R6: Any other opcode, including 6'h3B and 6'h1A, never changes the sequential fetch order.
- R7: An unstalled ex_redirect_i makes the next fetch ex_target_i with its low three bits cleared. No packet is presented in the two following cycles, and the target packet is presented in the third.
- R8: An execute redirect wins over a jump found in the same cycle. The jump packet is never presented, and pd_redirect_o stays 0 in that cycle.
- R9: While stall_i is high, the fetch address, the epoch and all stage registers hold, so every output holds across the stalled edge.
- R10: A returning packet issued before the latest redirect is discarded, and drop_o is 1 in the unstalled cycle where that happens. After a jump this is the cycle in which the jump packet is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze the whole front end |
| ex_redirect_i | input | 1 | Taken branch resolved in execute |
| ex_target_i | input | ADDR_W | Execute redirect target |
| imem_rdata_i | input | PKT_W | Packet read data, one cycle after the address |
| imem_addr_o | output | ADDR_W | Fetch address |
| imem_req_o | output | 1 | Memory read enable |
| pkt_valid_o | output | 1 | Packet presented to decode |
| pkt_addr_o | output | ADDR_W | Address of the presented packet |
| pkt_data_o | output | PKT_W | Presented packet |
| pkt_mask_o | output | PKT_W/INSN_W | Slots on the program path |
| pd_redirect_o | output | 1 | Predecode jump redirects fetch this cycle |
| drop_o | output | 1 | Returning packet discarded this cycle |

## Verification
The bench builds the block with a one-bit epoch and a reset vector of zero, and serves it from a 64-packet memory window. With the one-bit epoch, every redirect wraps the tag, so stale-packet rejection is exercised at its narrowest. Jump offsets from -8 to +7 are swept through one rewritable packet in each slot arrangement, and each sweep entry enters that packet through an execute redirect whose target carries a different low-bit pattern. A fixed program with a jump loop, conditional opcodes and a double-jump packet then runs under pseudo-random stalls, and an execute redirect is placed on the cycle in which a jump is found.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_PD  = 2'd1,
    NPC_EX  = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/fe_npc_gen.sv
module fe_npc_gen
  import fetch_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        ALIGN_W   = 3,
  parameter int unsigned        EPOCH_W   = 2,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               ex_redirect_i,
  input  logic [ADDR_W-1:0]  ex_target_i,
  input  logic               pd_hit_i,
  input  logic [ADDR_W-1:0]  pd_target_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [EPOCH_W-1:0] epoch_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  npc_sel_e            sel;
  logic [ADDR_W-1:0]   npc;
  logic [ADDR_W-1:0]   pc_q;
  logic [EPOCH_W-1:0]  epoch_q;

  // execute beats predecode beats sequential
  always_comb begin
    if (ex_redirect_i)  sel = NPC_EX;
    else if (pd_hit_i)  sel = NPC_PD;
    else                sel = NPC_SEQ;
  end

  always_comb begin
    unique case (sel)
      NPC_EX:  npc = ex_target_i;
      NPC_PD:  npc = pd_target_i;
      default: npc = pc_q + STEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_VEC;
      epoch_q <= '0;
    end else if (!stall_i) begin
      pc_q <= npc;
      if (sel != NPC_SEQ) epoch_q <= epoch_q + EPOCH_W'(1);
    end
  end

  assign pc_o    = pc_q;
  assign epoch_o = epoch_q;
endmodule

// File: rtl/fe_predecode.sv
module fe_predecode #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       ALIGN_W   = 3,
  parameter int unsigned       PKT_W     = 64,
  parameter int unsigned       INSN_W    = 32,
  parameter int unsigned       OPC_W     = 6,
  parameter logic [OPC_W-1:0]  UNCOND_OP = 6'h3A
) (
  input  logic                      live_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [PKT_W-1:0]          data_i,
  output logic                      hit_o,
  output logic [ADDR_W-1:0]         target_o,
  output logic [PKT_W/INSN_W-1:0]   mask_o
);
  localparam int unsigned NSLOT = PKT_W / INSN_W;
  localparam int unsigned OFF_W = INSN_W - OPC_W;

  logic [NSLOT-1:0]  is_jmp;
  logic [ADDR_W-1:0] slot_tgt [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [OPC_W-1:0] opc;
    logic [OFF_W-1:0] off;
    assign opc         = data_i[s*INSN_W + INSN_W - 1 -: OPC_W];
    assign off         = data_i[s*INSN_W +: OFF_W];
    assign is_jmp[s]   = (opc == UNCOND_OP);
    assign slot_tgt[s] = addr_i + (ADDR_W'($signed(off)) << ALIGN_W);
  end

  // lowest slot wins; slots after it leave the program path
  always_comb begin
    logic found;
    found    = 1'b0;
    target_o = addr_i;
    mask_o   = '1;
    for (int s = 0; s < NSLOT; s++) begin
      if (!found && is_jmp[s]) begin
        found    = 1'b1;
        target_o = slot_tgt[s];
        for (int j = 0; j < NSLOT; j++) begin
          if (j > s) mask_o[j] = 1'b0;
        end
      end
    end
    hit_o = live_i && found;
  end
endmodule

// File: rtl/fe_stage_regs.sv
module fe_stage_regs #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PKT_W   = 64,
  parameter int unsigned NSLOT   = 2,
  parameter int unsigned EPOCH_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               kill_i,
  input  logic [ADDR_W-1:0]  fe_addr_i,
  input  logic [EPOCH_W-1:0] epoch_i,
  input  logic [PKT_W-1:0]   rdata_i,
  input  logic [NSLOT-1:0]   mask_i,
  output logic [ADDR_W-1:0]  im_addr_o,
  output logic               live_o,
  output logic               drop_o,
  output logic               de_valid_o,
  output logic [ADDR_W-1:0]  de_addr_o,
  output logic [PKT_W-1:0]   de_data_o,
  output logic [NSLOT-1:0]   de_mask_o
);
  logic               im_valid_q;
  logic [ADDR_W-1:0]  im_addr_q;
  logic [EPOCH_W-1:0] im_epoch_q;
  logic               fresh;

  logic               de_valid_q;
  logic [ADDR_W-1:0]  de_addr_q;
  logic [PKT_W-1:0]   de_data_q;
  logic [NSLOT-1:0]   de_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      im_valid_q <= 1'b0;
      im_addr_q  <= '0;
      im_epoch_q <= '0;
    end else if (!stall_i) begin
      im_valid_q <= 1'b1;
      im_addr_q  <= fe_addr_i;
      im_epoch_q <= epoch_i;
    end
  end

  assign fresh  = (im_epoch_q == epoch_i) && !kill_i;
  assign live_o = im_valid_q && fresh;
  assign drop_o = im_valid_q && !fresh && !stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_valid_q <= 1'b0;
      de_addr_q  <= '0;
      de_data_q  <= '0;
      de_mask_q  <= '0;
    end else if (!stall_i) begin
      de_valid_q <= live_o;
      if (live_o) begin
        de_addr_q <= im_addr_q;
        de_data_q <= rdata_i;
        de_mask_q <= mask_i;
      end
    end
  end

  assign im_addr_o  = im_addr_q;
  assign de_valid_o = de_valid_q;
  assign de_addr_o  = de_addr_q;
  assign de_data_o  = de_data_q;
  assign de_mask_o  = de_mask_q;
endmodule

// File: rtl/fetch_predecode_top.sv
module fetch_predecode_top #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       PKT_W     = 64,
  parameter int unsigned       INSN_W    = 32,
  parameter int unsigned       OPC_W     = 6,
  parameter logic [OPC_W-1:0]  UNCOND_OP = 6'h3A,
  parameter int unsigned       EPOCH_W   = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stall_i,
  input  logic                     ex_redirect_i,
  input  logic [ADDR_W-1:0]        ex_target_i,
  input  logic [PKT_W-1:0]         imem_rdata_i,
  output logic [ADDR_W-1:0]        imem_addr_o,
  output logic                     imem_req_o,
  output logic                     pkt_valid_o,
  output logic [ADDR_W-1:0]        pkt_addr_o,
  output logic [PKT_W-1:0]         pkt_data_o,
  output logic [PKT_W/INSN_W-1:0]  pkt_mask_o,
  output logic                     pd_redirect_o,
  output logic                     drop_o
);
  localparam int unsigned NSLOT   = PKT_W / INSN_W;
  localparam int unsigned ALIGN_W = $clog2(PKT_W / 8);

  logic [ADDR_W-1:0]  ex_tgt;
  logic [ADDR_W-1:0]  pc;
  logic [EPOCH_W-1:0] epoch;
  logic [ADDR_W-1:0]  im_addr;
  logic               live;
  logic               pd_hit;
  logic [ADDR_W-1:0]  pd_target;
  logic [NSLOT-1:0]   pd_mask;

  assign ex_tgt = {ex_target_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  fe_npc_gen #(
    .ADDR_W   (ADDR_W),
    .ALIGN_W  (ALIGN_W),
    .EPOCH_W  (EPOCH_W),
    .RESET_VEC(RESET_VEC)
  ) u_npc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .ex_redirect_i(ex_redirect_i),
    .ex_target_i  (ex_tgt),
    .pd_hit_i     (pd_hit),
    .pd_target_i  (pd_target),
    .pc_o         (pc),
    .epoch_o      (epoch)
  );

  fe_stage_regs #(
    .ADDR_W (ADDR_W),
    .PKT_W  (PKT_W),
    .NSLOT  (NSLOT),
    .EPOCH_W(EPOCH_W)
  ) u_stages (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_i),
    .kill_i    (ex_redirect_i),
    .fe_addr_i (pc),
    .epoch_i   (epoch),
    .rdata_i   (imem_rdata_i),
    .mask_i    (pd_mask),
    .im_addr_o (im_addr),
    .live_o    (live),
    .drop_o    (drop_o),
    .de_valid_o(pkt_valid_o),
    .de_addr_o (pkt_addr_o),
    .de_data_o (pkt_data_o),
    .de_mask_o (pkt_mask_o)
  );

  fe_predecode #(
    .ADDR_W   (ADDR_W),
    .ALIGN_W  (ALIGN_W),
    .PKT_W    (PKT_W),
    .INSN_W   (INSN_W),
    .OPC_W    (OPC_W),
    .UNCOND_OP(UNCOND_OP)
  ) u_pd (
    .live_i  (live),
    .addr_i  (im_addr),
    .data_i  (imem_rdata_i),
    .hit_o   (pd_hit),
    .target_o(pd_target),
    .mask_o  (pd_mask)
  );

  assign imem_addr_o   = pc;
  assign imem_req_o    = !stall_i;
  assign pd_redirect_o = pd_hit && !stall_i;
endmodule

// File: rtl/fetch_predecode_chk.sv
module fetch_predecode_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 3,
  parameter int unsigned NSLOT   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              ex_redirect_i,
  input logic [ADDR_W-1:0] ex_target_i,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              pkt_valid_o,
  input logic [ADDR_W-1:0] pkt_addr_o,
  input logic [NSLOT-1:0]  pkt_mask_o,
  input logic              pd_redirect_o,
  input logic              drop_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  logic [ADDR_W-1:0] ex_al;
  assign ex_al = ex_target_i & ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !ex_redirect_i && !pd_redirect_o) |=> imem_addr_o == $past(imem_addr_o) + STEP);

  p_mask_head_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pkt_mask_o[0]);

  p_ex_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_redirect_i && !stall_i) |=> imem_addr_o == $past(ex_al));

  p_ex_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_redirect_i && !stall_i) |=> !pkt_valid_o);

  p_ex_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_redirect_i |-> !pd_redirect_o);

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(imem_addr_o) && $stable(pkt_valid_o) && $stable(pkt_addr_o)));

  p_jump_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_redirect_o |=> (stall_i || drop_o));
endmodule

bind fetch_predecode_top fetch_predecode_chk #(
  .ADDR_W (ADDR_W),
  .ALIGN_W(ALIGN_W),
  .NSLOT  (NSLOT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .ex_redirect_i(ex_redirect_i),
  .ex_target_i  (ex_target_i),
  .imem_addr_o  (imem_addr_o),
  .pkt_valid_o  (pkt_valid_o),
  .pkt_addr_o   (pkt_addr_o),
  .pkt_mask_o   (pkt_mask_o),
  .pd_redirect_o(pd_redirect_o),
  .drop_o       (drop_o)
);

// File: tb/fetch_predecode_top_tb_top.sv
module fetch_predecode_top_tb_top;
  localparam logic [5:0]  OP_JMP  = 6'h3A;
  localparam logic [5:0]  OP_PLN  = 6'h01;
  localparam logic [5:0]  OP_CND  = 6'h3B;
  localparam logic [5:0]  OP_NEAR = 6'h1A;
  localparam int          B_IDX   = 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic        ex_redirect_i = 1'b0;
  logic [31:0] ex_target_i = '0;
  logic [63:0] imem_rdata_i = '0;
  logic [31:0] imem_addr_o;
  logic        imem_req_o;
  logic        pkt_valid_o;
  logic [31:0] pkt_addr_o;
  logic [63:0] pkt_data_o;
  logic [1:0]  pkt_mask_o;
  logic        pd_redirect_o;
  logic        drop_o;

  always #5 clk = ~clk;

  fetch_predecode_top #(
    .ADDR_W(32), .PKT_W(64), .INSN_W(32), .OPC_W(6),
    .UNCOND_OP(OP_JMP), .EPOCH_W(1), .RESET_VEC(32'h0)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i),
    .ex_redirect_i(ex_redirect_i), .ex_target_i(ex_target_i),
    .imem_rdata_i(imem_rdata_i), .imem_addr_o(imem_addr_o),
    .imem_req_o(imem_req_o), .pkt_valid_o(pkt_valid_o),
    .pkt_addr_o(pkt_addr_o), .pkt_data_o(pkt_data_o),
    .pkt_mask_o(pkt_mask_o), .pd_redirect_o(pd_redirect_o),
    .drop_o(drop_o)
  );

  logic [63:0] mem [64];

  // R3: one-cycle read latency, read only when requested
  always @(posedge clk) if (imem_req_o) imem_rdata_i <= mem[imem_addr_o[8:3]];

  int    n_chk = 0;
  int    n_fail = 0;
  int    adv = 0;
  int    exp_adv = 0;
  int    n_cons = 0;
  logic [31:0] exp_addr = '0;
  string exp_tag = "R1";
  bit    mon_en = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input int off);
    logic [31:0] w;
    w = {op, off[25:0]};
    return w;
  endfunction

  function automatic logic [63:0] plain(input int idx);
    return {mk(OP_PLN, idx * 2 + 1), mk(OP_PLN, idx * 2)};
  endfunction

  function automatic logic [31:0] tgt(input logic [31:0] pa, input logic [31:0] ins);
    int o;
    o = $signed(ins[25:0]);
    return pa + 32'(o * 8);
  endfunction

  // monitor: packet order, timing, data, mask, stall hold
  logic        prev_stall = 1'b0;
  logic [31:0] prev_fa;
  logic        prev_v;
  logic [31:0] prev_pa;
  logic [63:0] prev_pd;

  always @(negedge clk) if (mon_en && !done) begin
    if (stall_i) chk(imem_req_o == 1'b0, "R3", 64'(imem_req_o), 64'd0);
    if (prev_stall) begin
      chk(imem_addr_o == prev_fa, "R9", 64'(imem_addr_o), 64'(prev_fa));
      chk(pkt_valid_o == prev_v && pkt_addr_o == prev_pa && pkt_data_o == prev_pd,
          "R9", 64'(pkt_addr_o), 64'(prev_pa));
    end
    if (!stall_i) begin
      if (pkt_valid_o && !ex_redirect_i) begin
        logic b0, b1, odd;
        n_cons++;
        chk(pkt_addr_o == exp_addr, exp_tag, 64'(pkt_addr_o), 64'(exp_addr));
        chk(adv == exp_adv, exp_tag, 64'(adv), 64'(exp_adv));
        chk(pkt_data_o == mem[pkt_addr_o[8:3]], "R2", pkt_data_o, mem[pkt_addr_o[8:3]]);
        b0  = pkt_data_o[31:26] == OP_JMP;
        b1  = pkt_data_o[63:58] == OP_JMP;
        odd = pkt_data_o[31:26] == OP_CND || pkt_data_o[63:58] == OP_CND ||
              pkt_data_o[31:26] == OP_NEAR || pkt_data_o[63:58] == OP_NEAR;
        chk(pkt_mask_o == (b0 ? 2'b01 : 2'b11), "R5", 64'(pkt_mask_o), b0 ? 64'd1 : 64'd3);
        if (b0 || b1) begin
          chk(drop_o == 1'b1, "R10", 64'(drop_o), 64'd1);
          exp_addr = b0 ? tgt(pkt_addr_o, pkt_data_o[31:0]) : tgt(pkt_addr_o, pkt_data_o[63:32]);
          exp_adv  = adv + 2;
          exp_tag  = (b0 && b1) ? "R5" : "R4";
        end else begin
          exp_addr = pkt_addr_o + 32'd8;
          exp_adv  = adv + 1;
          exp_tag  = odd ? "R6" : "R2";
        end
      end
      adv++;
    end
    prev_stall = stall_i;
    prev_fa    = imem_addr_o;
    prev_v     = pkt_valid_o;
    prev_pa    = pkt_addr_o;
    prev_pd    = pkt_data_o;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit          seen;
    for (int i = 0; i < 64; i++) mem[i] = plain(i);
    mem[2]  = {mk(OP_PLN, 5), mk(OP_CND, 7)};            // R6
    mem[3]  = {mk(OP_NEAR, -2), mk(OP_PLN, 6)};          // R6
    mem[5]  = {mk(OP_JMP, -5), mk(OP_JMP, 3)};           // R5: slot 0 wins -> idx 8
    mem[20] = {mk(OP_JMP, 9), mk(OP_JMP, 4)};            // R4: -> idx 24
    mem[26] = {mk(OP_JMP, -10), mk(OP_PLN, 52)};         // R4 slot 1 -> idx 16

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(imem_addr_o == 32'h0, "R1", 64'(imem_addr_o), 64'd0);
      chk(pkt_valid_o == 1'b0, "R1", 64'(pkt_valid_o), 64'd0);
    end
    @(posedge clk); #1;
    rst_ni   = 1'b1;
    exp_addr = 32'h0;
    exp_adv  = 2;
    exp_tag  = "R1";
    mon_en   = 1'b1;
    repeat (60) @(posedge clk);

    // R4/R5/R7: offset sweep through one rewritable packet
    for (int off = -8; off < 8; off++) begin
      for (int mode = 0; mode < 3; mode++) begin
        @(posedge clk); #1;
        case (mode)
          0:       mem[B_IDX] = {mk(OP_PLN, 1), mk(OP_JMP, off)};
          1:       mem[B_IDX] = {mk(OP_JMP, off), mk(OP_PLN, 1)};
          default: mem[B_IDX] = {mk(OP_JMP, -off - 1), mk(OP_JMP, off)};
        endcase
        ex_redirect_i = 1'b1;
        ex_target_i   = 32'(B_IDX * 8) | 32'((off + mode) & 7);
        exp_addr      = 32'(B_IDX * 8);
        exp_adv       = adv + 3;
        exp_tag       = "R7";
        @(posedge clk); #1;
        ex_redirect_i = 1'b0;
        repeat (6) @(posedge clk);
      end
    end

    // R9: pseudo-random stalls over the fixed program
    lfsr = 16'hACE1;
    ex_redirect_i = 1'b0;
    ex_target_i   = 32'h0;
    @(posedge clk); #1;
    ex_redirect_i = 1'b1;
    exp_addr = 32'h0;
    exp_adv  = adv + 3;
    exp_tag  = "R7";
    @(posedge clk); #1;
    ex_redirect_i = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1;
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall_i = (lfsr[1:0] == 2'b00);
    end
    @(posedge clk); #1;
    stall_i = 1'b0;

    // R8: execute redirect in the cycle a jump is found
    seen = 1'b0;
    for (int c = 0; c < 64; c++) begin
      @(posedge clk); #1;
      if (pd_redirect_o) begin
        seen          = 1'b1;
        ex_redirect_i = 1'b1;
        ex_target_i   = 32'h1A8;
        exp_addr      = 32'h1A8;
        exp_adv       = adv + 3;
        exp_tag       = "R8";
        break;
      end
    end
    chk(seen, "R8", 64'(seen), 64'd1);
    @(posedge clk); #1;
    ex_redirect_i = 1'b0;
    repeat (20) @(posedge clk);

    @(negedge clk); #1;
    chk(n_cons >= 200, "R2", 64'(n_cons), 64'd200);
    if (!done) begin
      done = 1'b1;
      summary();
    end
  end
endmodule